// File: doc/BRIEF.md
# Host/Processor Command and Status Mailbox

The mailbox sits between a host bus and a local processor and gives them a shared set of storage. Each side has its own word-wide port. Through that port it can reach a command word, a status word, a doorbell register and two 256-word data areas. The local processor owns none of the host's memory. Everything the two sides exchange lives inside this block.

A host transaction runs in three steps. The host fills the inbound data area, writes the command word and then rings the processor's doorbell. The processor takes the interrupt, reads the command and its data, and acknowledges to drop the interrupt. Traffic in the other direction uses the outbound area, the status word and the host's doorbell. The host may read the status word whenever it likes. The block also decodes the low bits of the command word into three flags: sampling control, parameter update and data upload.

Each port has an address of 10 bits. The upper two bits select a region: 00 is the register region, 01 is the inbound area (host to processor) and 10 is the outbound area (processor to host). The lower 8 bits are the offset within that region. Register offsets are 0 for the command word, 1 for the status word and 2 for the doorbell.

Top module: `mbox_top`

## Requirements
- R1: After reset, the command word and the status word both read 0000h, where a status of 0000h means normal operation, and both interrupt outputs are low.
- R2: A read (req=1, we=0) puts its data on that port's rdata on the next clock edge. The read returns the contents from before any write made in the same cycle. In any cycle that does not follow a read, rdata is 0. Register offsets other than 0 to 2, and region 11, read as 0.
- R3: Only the host can write the command word, at register offset 0. Both sides can read it. A processor write to offset 0 has no effect.
- R4: Only the processor can write the status word, at register offset 1. The host can read it at any time. A host write to offset 1 has no effect.
- R5: A host write to register offset 2 with bit 0 set raises s_irq_o on the next edge. A processor write to offset 2 with bit 0 set raises h_irq_o in the same way. Reading offset 2 returns bit 0 = s_irq_o and bit 1 = h_irq_o.
- R6: A write to offset 2 with bit 1 set clears the writer's own interrupt: the host clears h_irq_o and the processor clears s_irq_o. If the other side rings that same interrupt in the same cycle, the ring wins.
- R7: Both sides can read and write both data areas, each holding 256 words of 16 bits, selected by region 01 or 10 and an 8-bit offset.
- R8: If both sides write the same data word in the same cycle, the host's value is stored.
- R9: Command bits [1:0] drive the decode flags: 01 gives cmd_sample_o, 10 gives cmd_param_o, 11 gives cmd_upload_o and 00 gives no flag. At most one flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_req_i | input | 1 | Host access request |
| h_we_i | input | 1 | Host write enable |
| h_addr_i | input | 10 | Host address: region in [9:8], offset in [7:0] |
| h_wdata_i | input | 16 | Host write data |
| h_rdata_o | output | 16 | Host read data, one cycle after the request |
| h_irq_o | output | 1 | Interrupt to the host |
| s_req_i | input | 1 | Processor access request |
| s_we_i | input | 1 | Processor write enable |
| s_addr_i | input | 10 | Processor address: region in [9:8], offset in [7:0] |
| s_wdata_i | input | 16 | Processor write data |
| s_rdata_o | output | 16 | Processor read data, one cycle after the request |
| s_irq_o | output | 1 | Interrupt to the processor |
| cmd_sample_o | output | 1 | Command is sampling control |
| cmd_param_o | output | 1 | Command is a parameter update |
| cmd_upload_o | output | 1 | Command is a data upload |

## Verification
Every result of this block is due exactly one edge after the stimulus that causes it. Read data, interrupt changes and decode flags all appear one edge later, whether the stimulus was a request, a doorbell write or a command write. The bench drives inputs on the falling edge and updates a behavioural model from the same inputs. It then compares every output with the model on the next falling edge, which is one full register stage later. Directed checks for the collision, the set-against-clear race and the ignored writes sample their results in the same slot.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [1:0] RGN_REG = 2'b00;
  localparam logic [1:0] RGN_H2S = 2'b01;
  localparam logic [1:0] RGN_S2H = 2'b10;

  localparam int OFF_CMD  = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_BELL = 2;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_PARAM  = 2'b10,
    OP_UPLOAD = 2'b11
  } op_e;
endpackage

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_we_i,
  input  logic          h_re_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  input  logic          s_we_i,
  input  logic          s_re_i,
  input  logic [AW-1:0] s_addr_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [DW-1:0] s_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // slave write first, host write last: host wins on collision
  always_ff @(posedge clk_i) begin
    if (s_we_i) mem[s_addr_i] <= s_wdata_i;
    if (h_we_i) mem[h_addr_i] <= h_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_rdata_o <= '0;
      s_rdata_o <= '0;
    end else begin
      if (h_re_i) h_rdata_o <= mem[h_addr_i];
      if (s_re_i) s_rdata_o <= mem[s_addr_i];
    end
  end

  // R8
  host_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_we_i && s_we_i && h_addr_i == s_addr_i) |=> mem[$past(h_addr_i)] == $past(h_wdata_i));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_wr_i,
  input  logic [AW-1:0] h_off_i,
  input  logic [DW-1:0] h_wdata_i,
  input  logic          s_wr_i,
  input  logic [AW-1:0] s_off_i,
  input  logic [DW-1:0] s_wdata_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] status_o,
  output logic          h_irq_o,
  output logic          s_irq_o,
  output logic          cmd_sample_o,
  output logic          cmd_param_o,
  output logic          cmd_upload_o
);
  logic h_cmd_wr, s_stat_wr, h_bell, s_bell;
  logic h_ring, h_ack, s_ring, s_ack;

  assign h_cmd_wr  = h_wr_i && (h_off_i == AW'(OFF_CMD));
  assign s_stat_wr = s_wr_i && (s_off_i == AW'(OFF_STAT));
  assign h_bell    = h_wr_i && (h_off_i == AW'(OFF_BELL));
  assign s_bell    = s_wr_i && (s_off_i == AW'(OFF_BELL));
  assign h_ring    = h_bell && h_wdata_i[0];
  assign h_ack     = h_bell && h_wdata_i[1];
  assign s_ring    = s_bell && s_wdata_i[0];
  assign s_ack     = s_bell && s_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o    <= '0;
      status_o <= '0;
      h_irq_o  <= 1'b0;
      s_irq_o  <= 1'b0;
    end else begin
      if (h_cmd_wr)  cmd_o    <= h_wdata_i;
      if (s_stat_wr) status_o <= s_wdata_i;
      // ring beats a same-cycle acknowledge
      if (h_ring)     s_irq_o <= 1'b1;
      else if (s_ack) s_irq_o <= 1'b0;
      if (s_ring)     h_irq_o <= 1'b1;
      else if (h_ack) h_irq_o <= 1'b0;
    end
  end

  op_e op;
  assign op = op_e'(cmd_o[1:0]);

  always_comb begin
    cmd_sample_o = 1'b0;
    cmd_param_o  = 1'b0;
    cmd_upload_o = 1'b0;
    case (op)
      OP_SAMPLE: cmd_sample_o = 1'b1;
      OP_PARAM:  cmd_param_o  = 1'b1;
      OP_UPLOAD: cmd_upload_o = 1'b1;
      default: ;
    endcase
  end

  // R3
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_cmd_wr |=> $stable(cmd_o));
  // R4
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_stat_wr |=> $stable(status_o));
  // R5
  s_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ring |=> s_irq_o);
  // R5
  h_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ring |=> h_irq_o);
  // R6
  s_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ack && !h_ring) |=> !s_irq_o);
  // R6
  h_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ack && !s_ring) |=> !h_irq_o);
  // R9
  flag_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_sample_o, cmd_param_o, cmd_upload_o}));
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           h_req_i,
  input  logic           h_we_i,
  input  logic [AW+1:0]  h_addr_i,
  input  logic [DW-1:0]  h_wdata_i,
  output logic [DW-1:0]  h_rdata_o,
  output logic           h_irq_o,
  input  logic           s_req_i,
  input  logic           s_we_i,
  input  logic [AW+1:0]  s_addr_i,
  input  logic [DW-1:0]  s_wdata_i,
  output logic [DW-1:0]  s_rdata_o,
  output logic           s_irq_o,
  output logic           cmd_sample_o,
  output logic           cmd_param_o,
  output logic           cmd_upload_o
);
  localparam int NAREA = 2;

  logic [1:0]    h_rgn, s_rgn;
  logic [AW-1:0] h_off, s_off;
  logic          h_rd, h_wr, s_rd, s_wr;

  assign h_rgn = h_addr_i[AW +: 2];
  assign s_rgn = s_addr_i[AW +: 2];
  assign h_off = h_addr_i[AW-1:0];
  assign s_off = s_addr_i[AW-1:0];
  assign h_rd  = h_req_i && !h_we_i;
  assign h_wr  = h_req_i &&  h_we_i;
  assign s_rd  = s_req_i && !s_we_i;
  assign s_wr  = s_req_i &&  s_we_i;

  logic [DW-1:0] cmd_w, status_w;

  mbox_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .h_wr_i       (h_wr && h_rgn == RGN_REG),
    .h_off_i      (h_off),
    .h_wdata_i    (h_wdata_i),
    .s_wr_i       (s_wr && s_rgn == RGN_REG),
    .s_off_i      (s_off),
    .s_wdata_i    (s_wdata_i),
    .cmd_o        (cmd_w),
    .status_o     (status_w),
    .h_irq_o      (h_irq_o),
    .s_irq_o      (s_irq_o),
    .cmd_sample_o (cmd_sample_o),
    .cmd_param_o  (cmd_param_o),
    .cmd_upload_o (cmd_upload_o)
  );

  logic [DW-1:0] h_area_rd [NAREA];
  logic [DW-1:0] s_area_rd [NAREA];

  for (genvar g = 0; g < NAREA; g++) begin : g_area
    localparam logic [1:0] RC = 2'(g + 1);
    mbox_dpram #(.DW(DW), .AW(AW)) u_ram (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .h_we_i    (h_wr && h_rgn == RC),
      .h_re_i    (h_rd && h_rgn == RC),
      .h_addr_i  (h_off),
      .h_wdata_i (h_wdata_i),
      .h_rdata_o (h_area_rd[g]),
      .s_we_i    (s_wr && s_rgn == RC),
      .s_re_i    (s_rd && s_rgn == RC),
      .s_addr_i  (s_off),
      .s_wdata_i (s_wdata_i),
      .s_rdata_o (s_area_rd[g])
    );
  end

  function automatic logic [DW-1:0] reg_view(logic [AW-1:0] off, logic [DW-1:0] c,
                                             logic [DW-1:0] st, logic hi, logic si);
    case (int'(off))
      OFF_CMD:  return c;
      OFF_STAT: return st;
      OFF_BELL: return DW'({hi, si});
      default:  return '0;
    endcase
  endfunction

  logic [DW-1:0] h_reg_q, s_reg_q;
  logic [1:0]    h_sel_q, s_sel_q;
  logic          h_vld_q, s_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_reg_q <= '0;
      s_reg_q <= '0;
      h_sel_q <= RGN_REG;
      s_sel_q <= RGN_REG;
      h_vld_q <= 1'b0;
      s_vld_q <= 1'b0;
    end else begin
      h_vld_q <= h_rd;
      s_vld_q <= s_rd;
      if (h_rd) begin
        h_sel_q <= h_rgn;
        h_reg_q <= reg_view(h_off, cmd_w, status_w, h_irq_o, s_irq_o);
      end
      if (s_rd) begin
        s_sel_q <= s_rgn;
        s_reg_q <= reg_view(s_off, cmd_w, status_w, h_irq_o, s_irq_o);
      end
    end
  end

  always_comb begin
    h_rdata_o = '0;
    if (h_vld_q) begin
      case (h_sel_q)
        RGN_REG: h_rdata_o = h_reg_q;
        RGN_H2S: h_rdata_o = h_area_rd[0];
        RGN_S2H: h_rdata_o = h_area_rd[1];
        default: h_rdata_o = '0;
      endcase
    end
    s_rdata_o = '0;
    if (s_vld_q) begin
      case (s_sel_q)
        RGN_REG: s_rdata_o = s_reg_q;
        RGN_H2S: s_rdata_o = s_area_rd[0];
        RGN_S2H: s_rdata_o = s_area_rd[1];
        default: s_rdata_o = '0;
      endcase
    end
  end

  // R2
  h_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_rd |=> h_rdata_o == '0);
endmodule

// File: tb/mbox_top_test.sv
module mbox_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        h_req = 0, h_we = 0, s_req = 0, s_we = 0;
  logic [9:0]  h_addr = '0, s_addr = '0;
  logic [15:0] h_wd = '0, s_wd = '0;
  logic [15:0] h_rd, s_rd;
  logic        h_irq, s_irq, f_samp, f_param, f_upl;

  mbox_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_req_i(h_req), .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wd),
    .h_rdata_o(h_rd), .h_irq_o(h_irq),
    .s_req_i(s_req), .s_we_i(s_we), .s_addr_i(s_addr), .s_wdata_i(s_wd),
    .s_rdata_o(s_rd), .s_irq_o(s_irq),
    .cmd_sample_o(f_samp), .cmd_param_o(f_param), .cmd_upload_o(f_upl)
  );

  int checks = 0, fails = 0;

  // reference model
  logic [15:0] m_cmd = 0, m_stat = 0;
  bit          m_hirq = 0, m_sirq = 0;
  logic [15:0] m_mem [2][256];
  logic [15:0] e_hrd = 0, e_srd = 0;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(logic [9:0] a);
    case (a[9:8])
      2'b00: case (a[7:0])
               8'd0: return m_cmd;
               8'd1: return m_stat;
               8'd2: return {14'b0, m_hirq, m_sirq};
               default: return 16'h0;
             endcase
      2'b01: return m_mem[0][a[7:0]];
      2'b10: return m_mem[1][a[7:0]];
      default: return 16'h0;
    endcase
  endfunction

  task automatic compare_all();
    chk(h_rd === e_hrd, "R2 host rdata", h_rd, e_hrd);
    chk(s_rd === e_srd, "R2 slave rdata", s_rd, e_srd);
    chk(h_irq === m_hirq, "R5 h_irq", 16'(h_irq), 16'(m_hirq));
    chk(s_irq === m_sirq, "R5 s_irq", 16'(s_irq), 16'(m_sirq));
    chk({f_upl, f_param, f_samp} ===
        {m_cmd[1:0] == 2'b11, m_cmd[1:0] == 2'b10, m_cmd[1:0] == 2'b01},
        "R9 flags", 16'({f_upl, f_param, f_samp}), 16'(m_cmd[1:0]));
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit hr, bit hw, logic [9:0] ha, logic [15:0] hd,
                      bit sr, bit sw, logic [9:0] sa, logic [15:0] sd);
    logic [15:0] nh, ns;
    bit h_ring, h_ack, s_ring, s_ack;
    h_req = hr; h_we = hw; h_addr = ha; h_wd = hd;
    s_req = sr; s_we = sw; s_addr = sa; s_wd = sd;
    nh = (hr && !hw) ? m_read(ha) : 16'h0;
    ns = (sr && !sw) ? m_read(sa) : 16'h0;
    h_ring = hr && hw && ha == 10'd2 && hd[0];
    h_ack  = hr && hw && ha == 10'd2 && hd[1];
    s_ring = sr && sw && sa == 10'd2 && sd[0];
    s_ack  = sr && sw && sa == 10'd2 && sd[1];
    if (h_ring) m_sirq = 1; else if (s_ack) m_sirq = 0;
    if (s_ring) m_hirq = 1; else if (h_ack) m_hirq = 0;
    if (hr && hw && ha == 10'd0) m_cmd = hd;
    if (sr && sw && sa == 10'd1) m_stat = sd;
    if (sr && sw && sa[9:8] inside {2'b01, 2'b10}) m_mem[sa[9:8]-1][sa[7:0]] = sd;
    if (hr && hw && ha[9:8] inside {2'b01, 2'b10}) m_mem[ha[9:8]-1][ha[7:0]] = hd;
    e_hrd = nh; e_srd = ns;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0,0,0,0, 0,0,0,0); endtask
  task automatic hw_(logic [9:0] a, logic [15:0] d); step(1,1,a,d, 0,0,0,0); endtask
  task automatic sw_(logic [9:0] a, logic [15:0] d); step(0,0,0,0, 1,1,a,d); endtask
  task automatic hr_(logic [9:0] a); step(1,0,a,0, 0,0,0,0); endtask
  task automatic sr_(logic [9:0] a); step(0,0,0,0, 1,0,a,0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(h_irq === 0 && s_irq === 0, "R1 irqs low", 16'({h_irq, s_irq}), 16'h0);
    hr_(10'h000); chk(h_rd === 16'h0, "R1 cmd reset", h_rd, 16'h0);
    hr_(10'h001); chk(h_rd === 16'h0, "R1 status reset", h_rd, 16'h0);
    // prefill both areas, R7
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 256; i++)
        hw_(10'((r + 1) * 256 + i), 16'(i * 3 + r * 1000));
    // host sends command with data
    hw_(10'h105, 16'hBEEF);
    hw_(10'h000, 16'h0005);   // opcode 01 sampling
    chk(f_samp === 1 && f_param === 0 && f_upl === 0, "R9 sample flag", 16'({f_upl, f_param, f_samp}), 16'h1);
    hw_(10'h002, 16'h0001);
    chk(s_irq === 1, "R5 slave doorbell", 16'(s_irq), 16'h1);
    sr_(10'h000); chk(s_rd === 16'h0005, "R3 slave reads cmd", s_rd, 16'h0005);
    sr_(10'h105); chk(s_rd === 16'hBEEF, "R7 slave reads inbound", s_rd, 16'hBEEF);
    sr_(10'h002); chk(s_rd === 16'h0001, "R5 bell readback", s_rd, 16'h0001);
    sw_(10'h000, 16'h1234);   // ignored
    hr_(10'h000); chk(h_rd === 16'h0005, "R3 slave cmd write ignored", h_rd, 16'h0005);
    sw_(10'h002, 16'h0002);
    chk(s_irq === 0, "R6 slave ack", 16'(s_irq), 16'h0);
    // slave reports fault
    sw_(10'h203, 16'hCAFE);
    sw_(10'h001, 16'h8001);
    sw_(10'h002, 16'h0001);
    chk(h_irq === 1, "R5 host doorbell", 16'(h_irq), 16'h1);
    hw_(10'h001, 16'h7777);   // ignored
    hr_(10'h001); chk(h_rd === 16'h8001, "R4 status read, host write ignored", h_rd, 16'h8001);
    hr_(10'h203); chk(h_rd === 16'hCAFE, "R7 host reads outbound", h_rd, 16'hCAFE);
    hw_(10'h002, 16'h0002);
    chk(h_irq === 0, "R6 host ack", 16'(h_irq), 16'h0);
    // ring and ack race on s_irq: ring wins
    step(1,1,10'h002,16'h0001, 1,1,10'h002,16'h0002);
    chk(s_irq === 1, "R6 ring beats ack", 16'(s_irq), 16'h1);
    sw_(10'h002, 16'h0002);
    // R8 collision
    step(1,1,10'h10A,16'hAAAA, 1,1,10'h10A,16'h5555);
    sr_(10'h10A); chk(s_rd === 16'hAAAA, "R8 host wins", s_rd, 16'hAAAA);
    // R2 read-before-write
    step(1,0,10'h10A,0, 1,1,10'h10A,16'h1111);
    chk(h_rd === 16'hAAAA, "R2 old data on same-cycle write", h_rd, 16'hAAAA);
    hr_(10'h0F0); chk(h_rd === 16'h0, "R2 unmapped reg", h_rd, 16'h0);
    hr_(10'h300); chk(h_rd === 16'h0, "R2 region 11", h_rd, 16'h0);
    idle(); chk(h_rd === 16'h0, "R2 idle zero", h_rd, 16'h0);
    // R9 remaining opcodes
    hw_(10'h000, 16'h0002); chk(f_param === 1, "R9 param flag", 16'(f_param), 16'h1);
    hw_(10'h000, 16'h0003); chk(f_upl === 1, "R9 upload flag", 16'(f_upl), 16'h1);
    hw_(10'h000, 16'h0000);
    chk({f_upl, f_param, f_samp} === 3'b000, "R9 no flag", 16'({f_upl, f_param, f_samp}), 16'h0);
    // mixed traffic, compared on every clock
    for (int n = 0; n < 2000; n++) begin
      logic [9:0] ha, sa;
      ha = {2'($urandom_range(0, 3)), 8'($urandom_range(0, 7))};
      sa = {2'($urandom_range(0, 3)), 8'($urandom_range(0, 7))};
      step(1'($urandom), 1'($urandom), ha, 16'($urandom),
           1'($urandom), 1'($urandom), sa, 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule